// File: doc/BRIEF.md
# Two-Level Interrupt Status Controller

This block keeps an 8-bit processor status word and decides, each cycle, whether a maskable interrupt request is accepted. The word carries a global interrupt enable, an in-service priority bit, two register-bank select bits and the zero, carry and auxiliary-carry flags. Arithmetic flags are not computed here. They arrive only through the whole-word write port.

Accepting a request raises a combinational acknowledge in the same cycle. At the next clock edge the block saves the old word onto a four-entry internal LIFO, clears the global enable and copies the request's priority flag into the in-service bit. A software break saves the word and clears the enable whether or not interrupts are enabled. Push stores the word. Pop and return-from-interrupt (which also serves as return-from-break) restore the most recently saved word. The in-service bit blocks low-priority requests while a high-priority handler runs, which gives two levels of nesting.

Top module: `irq_status_ctrl`

## Requirements
- R1: After a synchronous active-low reset the word is 0x02 (enable 0, in-service bit 1), ack is 0 and the stack is empty.
- R2: ack is 1 exactly when req_valid=1, enable (bit 7) is 1, and either req_lowprio=0 (high priority) or the in-service bit (bit 1) is 1.
- R3: On an accepted request the next word has bit 7 = 0 and bit 1 = req_lowprio, with all other bits unchanged, and the previous word is pushed onto the stack.
- R4: A break strobe pushes the current word and clears bit 7 whatever its value. It leaves bit 1 unchanged and never raises ack.
- R5: ei_strobe sets bit 7 and di_strobe clears it. When both come in the same cycle, bit 7 ends at 0.
- R6: wr_en loads wr_data into the word, and bit 2 of the word always reads 0.
- R7: push_strobe stores the current word, which is visible on save_data, without changing it. pop_strobe and reti_strobe each restore the most recently saved entry (LIFO order), with bit 2 forced to 0.
- R8: A pop or return on an empty stack leaves the word unchanged.
- R9: The stack holds 4 entries. A save while it is full raises stack_ovf in that cycle and drops the entry. The save's other effects on the word still apply.
- R10: Same-cycle precedence is: accept or break, then restore, then write, then ei/di. A save in the same cycle as a restore suppresses the restore. An accepted request with ei_strobe leaves bit 7 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Maskable request pending |
| req_lowprio | input | 1 | Request priority flag: 1 low, 0 high |
| brk_strobe | input | 1 | Software break event |
| ei_strobe | input | 1 | Enable maskable interrupts |
| di_strobe | input | 1 | Disable maskable interrupts |
| wr_en | input | 1 | Whole-word write enable |
| wr_data | input | 8 | Whole-word write value |
| push_strobe | input | 1 | Save word to stack |
| pop_strobe | input | 1 | Restore word from stack |
| reti_strobe | input | 1 | Return from interrupt or break (restore) |
| psw | output | 8 | Current status word |
| ack | output | 1 | Request accepted this cycle |
| save_data | output | 8 | Word written to the stack on a save |
| stack_ovf | output | 1 | Save attempted while stack full |

## Verification
The bench nests a high-priority handler over a low-priority one and returns through both levels. A design that ignored the in-service bit would accept a low request during the high handler, and one that restored in FIFO order would return the wrong word at the second level. It fills the stack and attempts a fifth save, which would corrupt the oldest entry if overflow were not detected, and then pops past empty, where a design without an empty guard would load stale data. Simultaneous strobes check the precedence rules. An accept in the same cycle as ei must leave interrupts disabled, and a write in the same cycle as a pop must lose to the pop.

// File: rtl/irq_status_pkg.sv
// Package: shared constants for the interrupt status controller.
// Assumes an 8-bit status word with fixed bit positions.
package irq_status_pkg;
    localparam int WORD_W    = 8;
    localparam int BIT_IE    = 7;
    localparam int BIT_ZERO  = 6;
    localparam int BIT_BANK1 = 5;
    localparam int BIT_AUXC  = 4;
    localparam int BIT_BANK0 = 3;
    localparam int BIT_RSVD  = 2;
    localparam int BIT_ISP   = 1;
    localparam int BIT_CARRY = 0;

    localparam logic [WORD_W-1:0] WORD_RESET = 8'h02;
    localparam logic [WORD_W-1:0] WORD_MASK  = 8'hFB;

    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/irq_accept.sv
// Module: irq_accept
// Decides combinationally whether a pending maskable request is accepted.
// Assumes req_lowprio=1 marks a low-priority request.
module irq_accept (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_lowprio,
    input  logic ie,
    input  logic isp,
    output logic accept
);
    // Accept when enabled, and the request is high priority or no high handler runs.
    always_comb begin
        accept = req_valid && ie && (!req_lowprio || isp);
    end

    a_r2_low_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_lowprio && !isp) |-> !accept);
    a_r2_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ie);
endmodule

// File: rtl/word_stack.sv
// Module: word_stack
// LIFO of saved status words. A push while full is dropped and flagged,
// and a pop while empty is ignored. Assumes the caller never requests
// a push and a pop in the same cycle.
module word_stack #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic [WIDTH-1:0] push_data,
    output logic [WIDTH-1:0] top_data,
    output logic             empty,
    output logic             full,
    output logic             overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [CW-1:0]    count;
    logic [AW-1:0]    wr_idx;
    logic [AW-1:0]    rd_idx;

    // Status flags and entry indices derived from the fill count.
    always_comb begin
        empty    = (count == '0);
        full     = (count == FULL_CNT);
        overflow = push_req && full;
        wr_idx   = AW'(count);
        rd_idx   = AW'(count - 1'b1);
        top_data = empty ? '0 : mem[rd_idx];
    end

    // Fill count bookkeeping for accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (push_req && !full) begin
            count <= count + 1'b1;
        end else if (pop_req && !empty) begin
            count <= count - 1'b1;
        end
    end

    // Entry storage, one write port per generated slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (push_req && !full && (wr_idx == AW'(g))) begin
                mem[g] <= push_data;
            end
        end
    end

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    a_r9_full_push_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full) |=> full);
    a_r8_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && empty) |=> empty);
endmodule

// File: rtl/status_word.sv
// Module: status_word
// Holds the status word and applies one update per cycle in precedence
// order: save-and-clear, restore, write, enable/disable. Assumes
// restore_go is already suppressed by the caller when a save happens.
module status_word
    import irq_status_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  accept,
    input  logic  req_lowprio,
    input  logic  brk,
    input  logic  restore_go,
    input  word_t restore_data,
    input  logic  wr_en,
    input  word_t wr_data,
    input  logic  ei,
    input  logic  di,
    output word_t word
);
    // Status register update with fixed precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= WORD_RESET;
        end else if (accept || brk) begin
            word[BIT_IE] <= 1'b0;
            if (accept) begin
                word[BIT_ISP] <= req_lowprio;
            end
        end else if (restore_go) begin
            word <= restore_data & WORD_MASK;
        end else if (wr_en) begin
            word <= wr_data & WORD_MASK;
        end else if (di) begin
            word[BIT_IE] <= 1'b0;
        end else if (ei) begin
            word[BIT_IE] <= 1'b1;
        end
    end

    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> (word == WORD_RESET));
    a_r6_bit2_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !word[BIT_RSVD]);
    a_r3_isp_copy: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (word[BIT_ISP] == $past(req_lowprio)));
    a_r4_brk_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> !word[BIT_IE]);
    a_r10_accept_beats_ei: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ei) |=> !word[BIT_IE]);
endmodule

// File: rtl/irq_status_ctrl.sv
// Module: irq_status_ctrl (top)
// Two-level interrupt status controller: status word, acceptance logic
// and a save stack. Assumes all strobes are single-cycle, sampled at the
// rising clock edge.
module irq_status_ctrl
    import irq_status_pkg::*;
#(
    parameter int STACK_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_lowprio,
    input  logic       brk_strobe,
    input  logic       ei_strobe,
    input  logic       di_strobe,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       push_strobe,
    input  logic       pop_strobe,
    input  logic       reti_strobe,
    output logic [7:0] psw,
    output logic       ack,
    output logic [7:0] save_data,
    output logic       stack_ovf
);
    word_t word_q;
    word_t top_data;
    logic  accept;
    logic  save_any;
    logic  restore_go;
    logic  stk_empty;
    logic  stk_full;

    // Save and restore requests, with a save suppressing a restore.
    always_comb begin
        save_any   = accept || brk_strobe || push_strobe;
        restore_go = (pop_strobe || reti_strobe) && !save_any && !stk_empty;
    end

    irq_accept u_accept (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_lowprio (req_lowprio),
        .ie          (word_q[BIT_IE]),
        .isp         (word_q[BIT_ISP]),
        .accept      (accept)
    );

    word_stack #(.WIDTH(WORD_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (save_any),
        .pop_req   (restore_go),
        .push_data (word_q),
        .top_data  (top_data),
        .empty     (stk_empty),
        .full      (stk_full),
        .overflow  (stack_ovf)
    );

    status_word u_word (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .req_lowprio  (req_lowprio),
        .brk          (brk_strobe),
        .restore_go   (restore_go),
        .restore_data (top_data),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .ei           (ei_strobe),
        .di           (di_strobe),
        .word         (word_q)
    );

    // Port mapping of internal results.
    always_comb begin
        psw       = word_q;
        ack       = accept;
        save_data = word_q;
    end

    a_r3_ack_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !psw[BIT_IE]);
    a_r9_ovf_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        stack_ovf |-> stk_full);
    a_r4_brk_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_strobe && !req_valid) |-> !ack);
endmodule

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid, req_lowprio, brk_strobe, ei_strobe, di_strobe;
    logic       wr_en, push_strobe, pop_strobe, reti_strobe;
    logic [7:0] wr_data;
    logic [7:0] psw, save_data;
    logic       ack, stack_ovf;
    int         errors = 0;
    int         checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lowprio(req_lowprio),
        .brk_strobe(brk_strobe), .ei_strobe(ei_strobe), .di_strobe(di_strobe),
        .wr_en(wr_en), .wr_data(wr_data), .push_strobe(push_strobe),
        .pop_strobe(pop_strobe), .reti_strobe(reti_strobe), .psw(psw), .ack(ack),
        .save_data(save_data), .stack_ovf(stack_ovf)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; req_lowprio = 0; brk_strobe = 0; ei_strobe = 0; di_strobe = 0;
        wr_en = 0; wr_data = 8'h00; push_strobe = 0; pop_strobe = 0; reti_strobe = 0;
    endtask

    // Clock once, then clear the strobes away from the edge.
    task automatic tick();
        @(posedge clk); #1; idle();
    endtask

    task automatic write_word(input logic [7:0] v);
        wr_en = 1; wr_data = v; tick();
    endtask

    task automatic t_reset();
        idle(); rst_n = 0;
        repeat (2) @(posedge clk);
        #1; rst_n = 1;
        check("R1 reset word", psw, 8'h02);
        check("R1 reset ack", {7'd0, ack}, 8'h00);
        pop_strobe = 1; tick();
        check("R8 pop on empty after reset", psw, 8'h02);
    endtask

    task automatic t_write();
        write_word(8'hFF);
        check("R6 bit2 forced zero", psw, 8'hFB);
        write_word(8'h00);
        check("R6 write zero", psw, 8'h00);
    endtask

    task automatic t_eidi();
        ei_strobe = 1; tick();
        check("R5 ei sets", psw, 8'h80);
        di_strobe = 1; tick();
        check("R5 di clears", psw, 8'h00);
        ei_strobe = 1; di_strobe = 1; tick();
        check("R5 ei+di gives disabled", psw, 8'h00);
    endtask

    task automatic t_nesting();
        write_word(8'h83);
        req_valid = 1; req_lowprio = 1; #1;
        check("R2 low accepted isp=1", {7'd0, ack}, 8'h01);
        tick();
        check("R3 low accept word", psw, 8'h03);
        req_valid = 1; req_lowprio = 0; #1;
        check("R2 no accept when disabled", {7'd0, ack}, 8'h00);
        idle();
        reti_strobe = 1; tick();
        check("R7 reti restores", psw, 8'h83);
        req_valid = 1; req_lowprio = 0; #1;
        check("R2 high accepted", {7'd0, ack}, 8'h01);
        tick();
        check("R3 high accept word", psw, 8'h01);
        ei_strobe = 1; tick();
        req_valid = 1; req_lowprio = 1; #1;
        check("R2 low blocked in high handler", {7'd0, ack}, 8'h00);
        req_lowprio = 0; #1;
        check("R2 high nests", {7'd0, ack}, 8'h01);
        tick();
        check("R3 nested word", psw, 8'h01);
        reti_strobe = 1; tick();
        check("R7 LIFO level 2", psw, 8'h81);
        reti_strobe = 1; tick();
        check("R7 LIFO level 1", psw, 8'h83);
    endtask

    task automatic t_brk();
        write_word(8'hC2);
        brk_strobe = 1; #1;
        check("R4 break no ack", {7'd0, ack}, 8'h00);
        tick();
        check("R4 break clears ie", psw, 8'h42);
        pop_strobe = 1; tick();
        check("R4 break saved word", psw, 8'hC2);
    endtask

    task automatic t_push_pop();
        write_word(8'h51);
        push_strobe = 1; #1;
        check("R7 save_data", save_data, 8'h51);
        tick();
        check("R7 push leaves word", psw, 8'h51);
        write_word(8'h00);
        pop_strobe = 1; tick();
        check("R7 pop restores", psw, 8'h51);
    endtask

    task automatic t_overflow();
        logic [7:0] vals [4] = '{8'h10, 8'h20, 8'h40, 8'h01};
        for (int i = 0; i < 4; i++) begin
            write_word(vals[i]);
            push_strobe = 1; #1;
            check("R9 no ovf below full", {7'd0, stack_ovf}, 8'h00);
            tick();
        end
        write_word(8'h08);
        push_strobe = 1; #1;
        check("R9 ovf when full", {7'd0, stack_ovf}, 8'h01);
        tick();
        for (int i = 3; i >= 0; i--) begin
            pop_strobe = 1; tick();
            check("R9 entries intact", psw, vals[i]);
        end
        pop_strobe = 1; tick();
        check("R8 pop past empty", psw, 8'h10);
    endtask

    task automatic t_precedence();
        write_word(8'h00);
        wr_en = 1; wr_data = 8'h00; ei_strobe = 1; tick();
        check("R10 write beats ei", psw, 8'h00);
        write_word(8'h80);
        push_strobe = 1; tick();
        wr_en = 1; wr_data = 8'h11; pop_strobe = 1; tick();
        check("R10 restore beats write", psw, 8'h80);
        write_word(8'h82);
        req_valid = 1; req_lowprio = 0; ei_strobe = 1; tick();
        check("R10 accept beats ei", psw, 8'h00);
        pop_strobe = 1; tick();
        check("R3 accept saved word", psw, 8'h82);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_write();
        t_eidi();
        t_nesting();
        t_brk();
        t_push_pop();
        t_overflow();
        t_precedence();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule